// File: doc/BRIEF.md
# Serial Debug Port Shift Interface

This block joins an external debug tool, which talks over a one-bit serial link, to the debug-mode special-register accesses of a CPU core. One 35-bit shift register does all the work. The tool shifts frames into it, one bit per shift-clock edge. A mode input selects the shift clock: either rising edges of a dedicated debug clock, sampled in the system clock domain, or every system clock cycle. A finished frame either holds an instruction or a data word for the core, or it reloads a 9-bit trap-enable register. That register drives six trap enables, two breakpoint enables and a sync line into the core.

On the core side, two pseudo-registers are decoded from a special-register address, and only when the special-register attribute is asserted. Reading the instruction pseudo-register fetches the next debug instruction. Reading the data pseudo-register collects a word sent by the tool. A read stalls until a frame of the matching kind has arrived. If a frame of the wrong kind arrives, it is discarded and a sticky sequence-error flag is raised. Writing the data pseudo-register parallel-loads the shift register, and the tool clocks the word out on serial-out while it shifts in its next frame.

Top module: `dbg_shift_port`

## Requirements
- R1: An active-low reset clears the shift register, the trap-enable register, the sequence-error flag and the bit counter. After reset, serial-out, all trap outputs and cpu_rvalid are 0.
- R2: With clk_sel=0, one bit shifts on each clock cycle in which dbg_clk is sampled high after being sampled low. With clk_sel=1, one bit shifts on every clock cycle.
- R3: When the port is idle, a shifted-in 1 starts a frame. A frame is exactly 35 bits, sent in this order: the start bit, then a mode bit (0 = core frame, 1 = trap-enable frame), then a kind bit (0 = instruction, 1 = data), then a 32-bit payload, MSB first. While the port is idle, a shifted-in 0 is ignored.
- R4: A read of the instruction address (cpu_spr=1, cpu_we=0) stalls until an instruction frame is held. cpu_rvalid and cpu_ready are then high for one cycle, and cpu_rdata carries the payload.
- R5: A read of the data address works the same way for data frames. Each received frame is returned exactly once.
- R6: A write of the data address while the port is idle is accepted in the same cycle (cpu_ready=1). It loads the shift register with three zero bits above cpu_wdata. During the next frame, serial-out presents, before each shift, the bit about to leave the register: 0, 0, 0, then cpu_wdata from MSB to LSB.
- R7: A trap-enable frame loads payload bits [8:0] into the trap-enable register: trap_en=[5:0], brk_en=[7:6], vsync=[8]. It produces no read data. The trap outputs change at no other time.
- R8: A read that meets a held frame of the other kind discards that frame, sets seq_err and keeps stalling. seq_err stays set until a read completes.
- R9: While a received frame waits for the core, start bits are ignored, and the held frame is kept unchanged.
- R10: If a data write and a start bit arrive in the same idle cycle, the write is accepted and the start bit is dropped.
- R11: The hand-over to the core happens one cycle after the last bit. cpu_rvalid is low on the cycle that follows the final shift and can go high on the cycle after that.
- R12: A read without cpu_spr, or to any other address, gets no response and leaves a held frame in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 1 | Shift clock select: 0 = debug clock edges, 1 = every system cycle |
| dbg_clk | input | 1 | External debug shift clock, already synchronous |
| ser_in | input | 1 | Serial data from the tool |
| ser_out | output | 1 | Serial data to the tool (MSB of the shift register) |
| cpu_req | input | 1 | Core special-register access request |
| cpu_spr | input | 1 | Special-register attribute |
| cpu_addr | input | ADDR_W | Special-register address |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rvalid | output | 1 | Read data valid strobe |
| cpu_rdata | output | 32 | Read data |
| trap_en | output | 6 | Trap enable lines |
| brk_en | output | 2 | Breakpoint enable lines |
| vsync | output | 1 | Sync line to the core |
| seq_err | output | 1 | Sticky sequence-error status |

## Verification
Two events can fall in one idle cycle: a core write to the data address and the arrival of a start bit. The bench provokes this in every-cycle shift mode. It raises ser_in and presents the write on the same edge, then confirms three things: the write was accepted, serial-out shows the loaded zero header, and the next frame clocks out the written word bit-exact. A second overlap is a core read waiting while a frame of the wrong kind lands. Here the bench checks that seq_err rises, that no data is returned, and that the correct frame sent afterwards is delivered and clears the flag.

// File: rtl/dbg_shift_port.sv
module dbg_shift_port #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] IR_ADDR = 10'd630,
  parameter logic [ADDR_W-1:0] DR_ADDR = 10'd631,
  parameter int DATA_W = 32,
  parameter int TE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_sel,
  input  logic              dbg_clk,
  input  logic              ser_in,
  output logic              ser_out,
  input  logic              cpu_req,
  input  logic              cpu_spr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [5:0]        trap_en,
  output logic [1:0]        brk_en,
  output logic              vsync,
  output logic              seq_err
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sr;
  logic [CNT_W-1:0]   cnt;
  logic [TE_W-1:0]    tecr;
  logic               dck_q, done_q, pend, seq_q;

  wire hit_ir  = cpu_req & cpu_spr & (cpu_addr == IR_ADDR);
  wire hit_dr  = cpu_req & cpu_spr & (cpu_addr == DR_ADDR);
  wire rd_req  = (hit_ir | hit_dr) & ~cpu_we;
  wire match   = pend & (sr[FRAME_W-3] == hit_dr);
  wire idle    = (cnt == '0) & ~done_q & ~pend;
  wire wr_acc  = hit_dr & cpu_we & idle;
  wire strobe  = clk_sel | (dbg_clk & ~dck_q);
  wire start   = strobe & ser_in & idle & ~wr_acc;
  wire shift   = start | (strobe & (cnt != '0));

  assign cpu_rvalid = rd_req & match;
  assign cpu_ready  = cpu_we ? wr_acc : cpu_rvalid;
  assign cpu_rdata  = sr[DATA_W-1:0];
  assign ser_out    = sr[FRAME_W-1];
  assign trap_en    = tecr[5:0];
  assign brk_en     = tecr[7:6];
  assign vsync      = tecr[8];
  assign seq_err    = seq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      cnt    <= '0;
      tecr   <= '0;
      dck_q  <= 1'b0;
      done_q <= 1'b0;
      pend   <= 1'b0;
      seq_q  <= 1'b0;
    end else begin
      dck_q  <= dbg_clk;
      done_q <= shift & (cnt == LAST);
      if (wr_acc)
        sr <= {{(FRAME_W-DATA_W){1'b0}}, cpu_wdata};
      else if (shift)
        sr <= {sr[FRAME_W-2:0], ser_in};
      if (shift)
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      if (done_q) begin
        if (sr[FRAME_W-2]) tecr <= sr[TE_W-1:0];
        else               pend <= 1'b1;
      end else if (rd_req & pend) begin
        pend  <= 1'b0;
        seq_q <= ~match;
      end
    end
  end
endmodule

module dbg_shift_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_req,
  input logic       cpu_we,
  input logic       cpu_ready,
  input logic       cpu_rvalid,
  input logic       seq_err,
  input logic       ser_out,
  input logic [5:0] trap_en,
  input logic [1:0] brk_en,
  input logic       vsync,
  input logic       done_q
);
  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (trap_en == 6'd0 && brk_en == 2'd0 && !vsync && !seq_err && !ser_out)); // R1
  AST_RVALID_IS_READ: assert property (@(posedge clk) disable iff (!rst_n) cpu_rvalid |-> (cpu_req && !cpu_we && cpu_ready)); // R4
  AST_RVALID_ONCE: assert property (@(posedge clk) disable iff (!rst_n) cpu_rvalid |=> !cpu_rvalid); // R5
  AST_WRITE_LOADS_ZERO_HEAD: assert property (@(posedge clk) disable iff (!rst_n) (cpu_req && cpu_we && cpu_ready) |=> !ser_out); // R6
  AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done_q |=> $stable({vsync, brk_en, trap_en})); // R7
  AST_SEQ_RISE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) $rose(seq_err) |-> $past(cpu_req && !cpu_we && !cpu_rvalid)); // R8
  AST_SEQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) cpu_rvalid |=> !seq_err); // R8
endmodule

bind dbg_shift_port dbg_shift_port_chk u_chk (.*);

// File: tb/test_dbg_shift_port.sv
module test_dbg_shift_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] IR = 10'd630;
  localparam logic [9:0] DR = 10'd631;

  logic clk = 1'b0, rst_n = 1'b0, clk_sel = 1'b0, dbg_clk = 1'b0, ser_in = 1'b0;
  logic cpu_req = 1'b0, cpu_spr = 1'b0, cpu_we = 1'b0;
  logic [9:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic ser_out, cpu_ready, cpu_rvalid, vsync, seq_err;
  logic [31:0] cpu_rdata;
  logic [5:0] trap_en;
  logic [1:0] brk_en;

  int vectors = 0, miscompares = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic [34:0] cap;

  dbg_shift_port i_dbg_shift_port (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && cpu_rvalid) begin
      if (exp_q.size() == 0) check("R5 unexpected read", 64'd1, 64'd0);
      else check(tag_q.pop_front(), {32'd0, cpu_rdata}, {32'd0, exp_q.pop_front()});
    end
  end

  task automatic send_frame(input logic mode, input logic kind, input logic [31:0] pay);
    logic [34:0] bits;
    bits = {1'b1, mode, kind, pay};
    for (int i = 34; i >= 0; i--) begin
      @(negedge clk);
      cap[i] = ser_out;
      ser_in = bits[i];
      if (!clk_sel) begin
        dbg_clk = 1'b1;
        @(negedge clk);
        dbg_clk = 1'b0;
        @(negedge clk);
      end
    end
    @(negedge clk);
    ser_in = 1'b0;
  endtask

  task automatic cpu_read(input logic [9:0] addr, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    cpu_req = 1'b1; cpu_spr = 1'b1; cpu_we = 1'b0; cpu_addr = addr;
    forever begin
      #1;
      if (cpu_rvalid) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1 cpu_req = 1'b0;
  endtask

  task automatic cpu_write(input logic [31:0] w);
    @(negedge clk);
    cpu_req = 1'b1; cpu_spr = 1'b1; cpu_we = 1'b1; cpu_addr = DR; cpu_wdata = w;
    #1 check("R6 write ready", {63'd0, cpu_ready}, 64'd1);
    @(posedge clk);
    #1 begin cpu_req = 1'b0; cpu_we = 1'b0; end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check("R4 watchdog expired", 64'd1, 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    check("R1 reset trap", {55'd0, vsync, brk_en, trap_en}, 64'd0);
    check("R1 reset seq_err", {63'd0, seq_err}, 64'd0);
    check("R1 reset ser_out", {62'd0, ser_out, cpu_rvalid}, 64'd0);

    fork
      cpu_read(IR, 32'h7C00_02A6, "R2 R4 instruction read");
      send_frame(1'b0, 1'b0, 32'h7C00_02A6);
    join

    send_frame(1'b1, 1'b0, 32'h0000_01A5);
    repeat (3) @(negedge clk); #2;
    check("R7 R3 trap load A", {55'd0, vsync, brk_en, trap_en}, {55'd0, 1'b1, 2'b10, 6'h25});
    send_frame(1'b1, 1'b1, 32'hFFFF_FE5A);
    repeat (3) @(negedge clk); #2;
    check("R7 trap load B", {55'd0, vsync, brk_en, trap_en}, {55'd0, 1'b0, 2'b01, 6'h1A});

    fork
      cpu_read(IR, 32'h3860_0001, "R8 read after mismatch");
      begin
        send_frame(1'b0, 1'b1, 32'hDEAD_BEEF);
        repeat (4) @(negedge clk); #2;
        check("R8 seq_err set", {63'd0, seq_err}, 64'd1);
        check("R8 stall on mismatch", {63'd0, cpu_rvalid}, 64'd0);
        send_frame(1'b0, 1'b0, 32'h3860_0001);
      end
    join
    @(negedge clk); #2;
    check("R8 seq_err cleared", {63'd0, seq_err}, 64'd0);

    send_frame(1'b0, 1'b1, 32'h1234_5678);
    send_frame(1'b0, 1'b1, 32'h9ABC_DEF0);
    @(negedge clk);
    cpu_req = 1'b1; cpu_spr = 1'b0; cpu_we = 1'b0; cpu_addr = DR;
    repeat (3) @(negedge clk);
    #2 check("R12 no attribute no response", {63'd0, cpu_rvalid}, 64'd0);
    cpu_addr = 10'd17; cpu_spr = 1'b1;
    @(negedge clk);
    #2 check("R12 other address no response", {63'd0, cpu_rvalid}, 64'd0);
    cpu_req = 1'b0;
    cpu_read(DR, 32'h1234_5678, "R9 R12 held frame kept");

    cpu_write(32'hA5C3_0F96);
    fork
      cpu_read(IR, 32'h4C00_0064, "R4 read with duplex");
      send_frame(1'b0, 1'b0, 32'h4C00_0064);
    join
    check("R6 serial-out word", {29'd0, cap}, {32'd0, 3'b000, 32'hA5C3_0F96});

    clk_sel = 1'b1;
    @(negedge clk);
    ser_in = 1'b1; cpu_req = 1'b1; cpu_spr = 1'b1; cpu_we = 1'b1; cpu_addr = DR; cpu_wdata = 32'h0F1E_2D3C;
    #1 check("R10 write wins ready", {63'd0, cpu_ready}, 64'd1);
    @(negedge clk);
    ser_in = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0;
    #2 check("R10 start dropped ser_out", {63'd0, ser_out}, 64'd0);
    @(negedge clk);
    exp_q.push_back(32'hCAFE_F00D);
    tag_q.push_back("R2 R5 data read every-cycle mode");
    cpu_req = 1'b1; cpu_spr = 1'b1; cpu_we = 1'b0; cpu_addr = DR;
    send_frame(1'b0, 1'b1, 32'hCAFE_F00D);
    #2 check("R11 no strobe after last bit", {63'd0, cpu_rvalid}, 64'd0);
    @(negedge clk); #2;
    check("R11 strobe one cycle later", {63'd0, cpu_rvalid}, 64'd1);
    @(posedge clk);
    #1 cpu_req = 1'b0;
    check("R10 serial-out word", {29'd0, cap}, {32'd0, 3'b000, 32'h0F1E_2D3C});

    repeat (4) @(negedge clk);
    check("R5 all reads returned", {32'd0, 32'(exp_q.size())}, 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule